// File: doc/BRIEF.md
# Multi-Mode Bipolar Line Encoder

This block turns a serial unipolar bit stream into a pair of rails. One rail carries the positive marks and the other carries the negative marks. Combined outside the block, the two rails form a ternary line signal of the alternate-mark family. A two-bit mode input selects the coding rule at run time: plain alternate mark inversion, or one of three zero-substitution codes. The substitution codes replace a run of 8, 6 or 4 zeros with a fixed pattern that carries deliberate polarity violations. That pattern keeps the pulse density high enough for clock recovery further down the line.

Input bits are captured on the falling clock edge and pass through a lookahead window of `DEPTH` bits. This lets the encoder see a whole zero run before its first bit leaves, so it can replace the run in one piece. The substitution controller has two states. `ST_PASS` emits marks and plain zeros. It moves to `ST_SUB` when the head of the window starts a complete zero run for the selected code, and emits the first pattern symbol in that cycle. `ST_SUB` plays out the rest of the latched pattern and returns to `ST_PASS` on its last symbol. A final output register applies two overrides. The blank input forces both rails low. The alarm input drives both rails high.

Top module: `bpl_line_encoder`

## Requirements
- R1: The `mode` input selects the code: 2'b00 plain alternate mark inversion, 2'b01 eight-zero substitution, 2'b10 six-zero substitution, 2'b11 four-zero high-density code. A positive pulse is `rail_p`=1 with `rail_n`=0. A negative pulse is `rail_n`=1 with `rail_p`=0.
- R2: Every 1 becomes a pulse of the polarity opposite to the previous pulse. A 0 that is not part of a substitution gives no pulse. In mode 2'b00, zero runs of any length stay empty. The encoder never drives both rails for one bit.
- R3: In mode 2'b01, eight zeros become 000+-0-+ after a positive pulse and 000-+0+- after a negative pulse. Seven zeros stay empty.
- R4: In mode 2'b10, six zeros become 0+-0-+ after a positive pulse and 0-+0+- after a negative pulse.
- R5: In mode 2'b11, four zeros become 000V if an odd number of data marks has been sent since the last substitution, and B00V if that number is even. V has the polarity of the preceding pulse, and B has the opposite polarity. The count restarts at even after reset and after each substitution.
- R6: The polarity state follows every pulse sent, inserted B and V pulses included. Successive four-zero violations therefore alternate in polarity.
- R7: The delay is fixed. A bit captured at the falling edge in cycle c drives the rails from the rising edge of cycle c+DEPTH+1 (9 cycles by default). The rails stay low until the first captured bit arrives.
- R8: `din` is sampled only on the falling clock edge. A change after that edge does not alter the bit encoded for that cycle.
- R9: `blank`=1 at a rising edge forces both rails to 0 for the next cycle, whatever the state of `alarm`.
- R10: `alarm`=1 with `blank`=0 at a rising edge drives both rails to 1 for the next cycle.
- R11: `rst_n`=0 clears every register. The rails are 0 during reset, even with alarm high. The first mark after reset is positive.
- R12: `blank` and `alarm` act on the rails only. The encoder keeps its polarity, parity and window state, so coding resumes correctly when they drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encode clock; data captured on falling edge, rails on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Code select (see R1) |
| din | input | 1 | Serial unipolar data |
| blank | input | 1 | Forces both rails low |
| alarm | input | 1 | Forces both rails high when not blanked |
| rail_p | output | 1 | Positive-mark rail |
| rail_n | output | 1 | Negative-mark rail |

## Verification
Each code gets a directed stream. Its zero runs sit after both positive and negative pulses, so the two polarity variants of each pattern are told apart. Runs one bit shorter than the substitution length separate "substitute" from "leave empty". Plain mode gets runs longer than any pattern to show that it never substitutes. For the four-zero code, runs fall after odd and even mark counts and back to back, which exposes errors in both the parity rule and the alternation of violations. Sparse pseudo-random streams in every mode, one with `din` glitched after each falling edge, and one with blank and alarm windows placed mid-stream, are compared cycle by cycle against an independent model at the fixed 9-cycle latency.

// File: rtl/bpl_pkg.sv
package bpl_pkg;
    typedef enum logic [1:0] {
        MODE_AMI  = 2'b00,
        MODE_B8ZS = 2'b01,
        MODE_B6ZS = 2'b10,
        MODE_HDB3 = 2'b11
    } line_mode_e;

    typedef enum logic {
        ST_PASS = 1'b0,
        ST_SUB  = 1'b1
    } sub_state_e;
endpackage

// File: rtl/bpl_sampler.sv
module bpl_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic din_q
);
    // capture on the falling edge, half a period ahead of the shift
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din;
    end
endmodule

// File: rtl/bpl_window.sv
module bpl_window #(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din_q,
    output logic [DEPTH-1:0] bits,
    output logic [DEPTH-1:0] vld
);
    // index 0 is the head (oldest bit); new bits enter at DEPTH-1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits <= '0;
            vld  <= '0;
        end else begin
            bits <= {din_q, bits[DEPTH-1:1]};
            vld  <= {1'b1,  vld[DEPTH-1:1]};
        end
    end
endmodule

// File: rtl/bpl_subst_core.sv
module bpl_subst_core
    import bpl_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  line_mode_e       mode,
    input  logic [DEPTH-1:0] bits,
    input  logic [DEPTH-1:0] vld,
    output logic             sym_p,
    output logic             sym_n
);
    localparam int CW = $clog2(DEPTH + 1);

    sub_state_e       st, st_d;
    logic [CW-1:0]    left, left_d, run_len;
    logic [DEPTH-1:0] pat_p, pat_n, pat_p_d, pat_n_d;
    logic [DEPTH-1:0] mask_same, mask_opp, lay_p, lay_n;
    logic             last_pos, odd, run_ok, start, data_mark;

    // pattern shape per code: "same" = polarity of the last pulse
    always_comb begin
        run_len   = '0;
        mask_same = '0;
        mask_opp  = '0;
        unique case (mode)
            MODE_AMI: begin
                run_len = '0;
            end
            MODE_B8ZS: begin
                run_len   = CW'(8);
                mask_same = DEPTH'(8'b1000_1000);
                mask_opp  = DEPTH'(8'b0101_0000);
            end
            MODE_B6ZS: begin
                run_len   = CW'(6);
                mask_same = DEPTH'(6'b10_0010);
                mask_opp  = DEPTH'(6'b01_0100);
            end
            MODE_HDB3: begin
                run_len = CW'(4);
                if (odd) mask_same = DEPTH'(4'b1000);
                else     mask_opp  = DEPTH'(4'b1001);
            end
        endcase
    end

    always_comb begin
        run_ok = (run_len != '0);
        for (int k = 0; k < DEPTH; k++) begin
            if (k < int'(run_len)) run_ok = run_ok & vld[k] & ~bits[k];
        end
        lay_p = last_pos ? mask_same : mask_opp;
        lay_n = last_pos ? mask_opp  : mask_same;
    end

    // next state and symbol
    always_comb begin
        st_d      = st;
        left_d    = left;
        pat_p_d   = pat_p;
        pat_n_d   = pat_n;
        sym_p     = 1'b0;
        sym_n     = 1'b0;
        start     = 1'b0;
        data_mark = 1'b0;
        unique case (st)
            ST_PASS: begin
                if (run_ok) begin
                    start   = 1'b1;
                    sym_p   = lay_p[0];
                    sym_n   = lay_n[0];
                    pat_p_d = lay_p >> 1;
                    pat_n_d = lay_n >> 1;
                    left_d  = run_len - CW'(1);
                    st_d    = ST_SUB;
                end else if (vld[0] && bits[0]) begin
                    data_mark = 1'b1;
                    sym_p     = ~last_pos;
                    sym_n     = last_pos;
                end
            end
            ST_SUB: begin
                sym_p   = pat_p[0];
                sym_n   = pat_n[0];
                pat_p_d = pat_p >> 1;
                pat_n_d = pat_n >> 1;
                left_d  = left - CW'(1);
                if (left == CW'(1)) st_d = ST_PASS;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_PASS;
            left     <= '0;
            pat_p    <= '0;
            pat_n    <= '0;
            last_pos <= 1'b0;
            odd      <= 1'b0;
        end else begin
            st    <= st_d;
            left  <= left_d;
            pat_p <= pat_p_d;
            pat_n <= pat_n_d;
            if (sym_p)      last_pos <= 1'b1;
            else if (sym_n) last_pos <= 1'b0;
            if (start)          odd <= 1'b0;
            else if (data_mark) odd <= ~odd;
        end
    end

    assert_one_rail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sym_p && sym_n));

    assert_ami_no_subst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PASS && mode == MODE_AMI) |=> (st == ST_PASS));
endmodule

// File: rtl/bpl_line_gate.sv
module bpl_line_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_p,
    input  logic sym_n,
    input  logic blank,
    input  logic alarm,
    output logic rail_p,
    output logic rail_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rail_p <= 1'b0;
            rail_n <= 1'b0;
        end else if (blank) begin
            rail_p <= 1'b0;
            rail_n <= 1'b0;
        end else if (alarm) begin
            rail_p <= 1'b1;
            rail_n <= 1'b1;
        end else begin
            rail_p <= sym_p;
            rail_n <= sym_n;
        end
    end

    assert_blank_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (!rail_p && !rail_n));

    assert_alarm_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && alarm) |=> (rail_p && rail_n));
endmodule

// File: rtl/bpl_line_encoder.sv
module bpl_line_encoder
    import bpl_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       din,
    input  logic       blank,
    input  logic       alarm,
    output logic       rail_p,
    output logic       rail_n
);
    logic             din_q;
    logic [DEPTH-1:0] bits, vld;
    logic             sym_p, sym_n;

    bpl_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .din(din), .din_q(din_q)
    );

    bpl_window #(.DEPTH(DEPTH)) u_win (
        .clk(clk), .rst_n(rst_n), .din_q(din_q), .bits(bits), .vld(vld)
    );

    bpl_subst_core #(.DEPTH(DEPTH)) u_core (
        .clk(clk), .rst_n(rst_n), .mode(line_mode_e'(mode)),
        .bits(bits), .vld(vld), .sym_p(sym_p), .sym_n(sym_n)
    );

    bpl_line_gate u_gate (
        .clk(clk), .rst_n(rst_n), .sym_p(sym_p), .sym_n(sym_n),
        .blank(blank), .alarm(alarm), .rail_p(rail_p), .rail_n(rail_n)
    );
endmodule

// File: tb/tb_bpl_line_encoder.sv
`timescale 1ns/1ps
module tb_bpl_line_encoder;
    localparam int LAT = 9;
    localparam int MAXB = 256;

    logic clk = 1'b0, rst_n = 1'b0, din = 1'b0, blank = 1'b0, alarm = 1'b0;
    logic [1:0] mode = 2'b00;
    logic rail_p, rail_n;

    int compared = 0, mismatched = 0;
    int bits [MAXB];
    int exs  [MAXB];
    int bl   [MAXB];
    int al   [MAXB];
    logic [1:0] obs [MAXB];
    int nb;
    logic [15:0] lfsr;

    always #10 clk = ~clk;

    bpl_line_encoder dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .din(din),
        .blank(blank), .alarm(alarm), .rail_p(rail_p), .rail_n(rail_n)
    );

    initial begin
        #(20 * 200000);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    task automatic clear_stream();
        for (int i = 0; i < MAXB; i++) begin
            bits[i] = 0; bl[i] = 0; al[i] = 0; exs[i] = 0;
        end
        nb = 0;
    endtask

    task automatic push(input int b, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            bits[nb] = b;
            nb++;
        end
    endtask

    task automatic push_lfsr(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            push(int'(lfsr[0] & lfsr[5]), 1);
        end
    endtask

    // independent model: -1 / 0 / +1 per bit
    task automatic model(input int md);
        int last, par, i, rl;
        int c [8];
        last = -1; par = 0; i = 0;
        rl = (md == 1) ? 8 : (md == 2) ? 6 : (md == 3) ? 4 : 0;
        while (i < nb + LAT) begin
            bit allz;
            allz = (rl > 0);
            for (int j = 0; j < rl; j++) if (bits[i + j] != 0) allz = 0;
            if (allz) begin
                case (md)
                    1: c = '{0, 0, 0, 1, -1, 0, -1, 1};
                    2: c = '{0, 1, -1, 0, -1, 1, 0, 0};
                    default: c = par ? '{0, 0, 0, 1, 0, 0, 0, 0}
                                     : '{-1, 0, 0, -1, 0, 0, 0, 0};
                endcase
                for (int j = 0; j < rl; j++) exs[i + j] = c[j] * last;
                last = c[rl - 1] * last;
                par = 0;
                i += rl;
            end else if (bits[i] != 0) begin
                last = -last;
                exs[i] = last;
                par ^= 1;
                i++;
            end else begin
                exs[i] = 0;
                i++;
            end
        end
    endtask

    task automatic chk(input string tag, input int k, input logic [1:0] got, input logic [1:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s cycle %0d rails got %b expected %b", tag, k, got, exp);
        end
    endtask

    // reset with alarm high, stream the bits, then compare each cycle
    task automatic run_stream(input int md, input bit glitch, input string tag);
        logic [1:0] e;
        model(md);
        mode = md[1:0];
        rst_n = 1'b0; alarm = 1'b1; blank = 1'b0; din = 1'b0;
        repeat (3) @(posedge clk);
        for (int c = 0; c < nb + LAT; c++) begin
            @(posedge clk);
            #1 obs[c] = {rail_p, rail_n};
            #1;
            rst_n = 1'b1;
            din   = (c < nb) ? bits[c][0] : 1'b0;
            blank = bl[c][0];
            alarm = al[c][0];
            if (glitch) begin
                @(negedge clk);
                #2 din = ~din;
            end
        end
        blank = 1'b0; alarm = 1'b0;
        for (int k = 0; k < nb + LAT; k++) begin
            if (k == 0)             chk("R11 reset", k, obs[k], 2'b00);
            else if (bl[k-1] != 0)  chk("R9 blank", k, obs[k], 2'b00);
            else if (al[k-1] != 0)  chk("R10 alarm", k, obs[k], 2'b11);
            else if (k < LAT)       chk("R7 fill", k, obs[k], 2'b00);
            else begin
                e = {exs[k-LAT] == 1, exs[k-LAT] == -1};
                chk(tag, k, obs[k], e);
            end
        end
    endtask

    task automatic t_ami();
        clear_stream();
        push(1, 1); push(0, 10); push(1, 2); push(0, 1); push(1, 1); push(0, 16); push(1, 3);
        run_stream(0, 1'b0, "R1 R2 R11 ami");
    endtask

    task automatic t_b8zs();
        clear_stream();
        push(1, 1); push(0, 8); push(1, 1); push(0, 8); push(1, 2); push(0, 7);
        push(1, 1); push(0, 9); push(1, 1); push(0, 16); push(1, 1);
        run_stream(1, 1'b0, "R1 R3 b8zs");
    endtask

    task automatic t_b6zs();
        clear_stream();
        push(1, 1); push(0, 6); push(1, 1); push(0, 6); push(1, 2); push(0, 5);
        push(1, 1); push(0, 13); push(1, 1);
        run_stream(2, 1'b0, "R1 R4 b6zs");
    endtask

    task automatic t_hdb3();
        clear_stream();
        push(0, 4); push(1, 1); push(0, 4); push(0, 4); push(1, 2); push(0, 4);
        push(1, 1); push(0, 3); push(1, 3); push(0, 12); push(1, 1);
        run_stream(3, 1'b0, "R1 R5 R6 hdb3");
    endtask

    task automatic t_random();
        for (int m = 0; m < 4; m++) begin
            clear_stream();
            lfsr = 16'hACE1 + 16'(m);
            push_lfsr(110);
            run_stream(m, 1'b0, "R6 pseudo-random");
        end
    endtask

    task automatic t_glitch();
        clear_stream();
        lfsr = 16'h1F2E;
        push_lfsr(80);
        run_stream(1, 1'b1, "R8 falling-edge sample");
        clear_stream();
        lfsr = 16'h7001;
        push_lfsr(60);
        run_stream(3, 1'b1, "R8 falling-edge sample");
    endtask

    task automatic t_overrides();
        clear_stream();
        lfsr = 16'h3C3C;
        push_lfsr(90);
        for (int c = 20; c < 24; c++) bl[c] = 1;
        for (int c = 34; c < 39; c++) al[c] = 1;
        for (int c = 50; c < 53; c++) begin bl[c] = 1; al[c] = 1; end
        run_stream(3, 1'b0, "R12 override transparency");
    endtask

    initial begin
        t_ami();
        t_b8zs();
        t_b6zs();
        t_hdb3();
        t_random();
        t_glitch();
        t_overrides();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule